// File: doc/BRIEF.md
# Two-Level Space Vector PWM Sequencer

This block drives the six gates of a two-level, three-phase inverter bridge over a fixed sampling period. At the start of every period it captures a sector number and two active-vector dwell times supplied by an upstream calculator. It derives the zero-vector time as whatever remains of the period. It then steps the three legs through a symmetric seven-segment pattern. The pattern opens and closes on the all-low state, with the all-high state in the middle. Adjacent states differ in exactly one leg.

The state of each leg is encoded as a three-bit word `{A,B,C}`. A 1 turns that leg's upper switch on and its lower switch off; a 0 does the reverse. The active vectors are numbered V1..V6 = 100, 110, 010, 011, 001, 101. Sector k uses Va = Vk and Vb = V(k mod 6 + 1). The dwell time `ta_in` belongs to Va and `tb_in` belongs to Vb.

The period length is the parameter `PER` in clock cycles. Angle and sine arithmetic are done elsewhere.

Top module: `svpwm_seq`

## Requirements
- R1: While `rst` is high, `gate_hi` is 000, `gate_lo` is 111 and `period_start` is 0.
- R2: After reset, `period_start` is high for exactly one cycle every `PER` cycles, marking count 0 of a period.
- R3: `sector_in`, `ta_in` and `tb_in` are captured only on the edge that begins a period. Changes during a period have no effect on that period's gates. `sector_o` shows the captured sector for the whole period.
- R4: For an odd sector (1, 3, 5), the segment order is 000, Va, Vb, 111, 111, Vb, Va, 000.
- R5: For an even sector (2, 4, 6), the two active vectors swap places: 000, Vb, Va, 111, 111, Va, Vb, 000. Sector 6 wraps so that Vb = V1.
- R6: With T0 = PER − Ta − Tb, each of the first three zero segments lasts floor(T0/4) cycles. Each Va segment lasts floor(Ta/2) and each Vb segment lasts floor(Tb/2). The closing 000 segment takes the remainder of the period. A segment of length 0 is skipped.
- R7: A captured Ta above `PER` is reduced to `PER`. If Ta + Tb then exceeds `PER`, Tb is reduced to `PER` − Ta, so T0 is 0.
- R8: Within a period in which every zero and active segment length is non-zero, each change of `gate_hi` toggles exactly one leg.
- R9: A captured sector of 0 or 7 holds `gate_hi` at 000 for the whole period.
- R10: `gate_lo` is always the bitwise complement of `gate_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sector_in | input | 3 | Sector number 1..6; 0 and 7 are invalid |
| ta_in | input | TW | Dwell time of Va in cycles |
| tb_in | input | TW | Dwell time of Vb in cycles |
| gate_hi | output | 3 | Upper-switch gates {A,B,C} |
| gate_lo | output | 3 | Lower-switch gates {A,B,C} |
| period_start | output | 1 | High on count 0 of each period |
| sector_o | output | 3 | Sector captured for the current period |
| seg_o | output | 3 | Current segment index 0..7 |

## Verification
Several properties are checked by assertions on every cycle:
- the start pulse lasts a single cycle;
- the captured sector stays stable between starts;
- the segment index never moves backwards inside a period;
- an invalid sector forces the zero state;
- a period with a non-zero opening segment opens on 000;
- a period with all segment lengths non-zero changes only one leg per step.

The exact segment order for each sector, the segment lengths with their rounding and remainder, the clamping of oversized dwell times, and the immunity to mid-period input changes can only be shown by the bench's scenarios. The bench compares every cycle against an independently computed sequence.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  // Active vector k (1..6) as {A,B,C}; 000 for anything else.
  function automatic logic [2:0] active_vec(input logic [2:0] k);
    case (k)
      3'd1:    active_vec = 3'b100;
      3'd2:    active_vec = 3'b110;
      3'd3:    active_vec = 3'b010;
      3'd4:    active_vec = 3'b011;
      3'd5:    active_vec = 3'b001;
      3'd6:    active_vec = 3'b101;
      default: active_vec = 3'b000;
    endcase
  endfunction

  // Neighbouring sector, wrapping 6 back to 1.
  function automatic logic [2:0] next_sector(input logic [2:0] k);
    next_sector = (k == 3'd6) ? 3'd1 : k + 3'd1;
  endfunction

  function automatic logic sector_ok(input logic [2:0] k);
    sector_ok = (k >= 3'd1) && (k <= 3'd6);
  endfunction

endpackage

// File: rtl/svpwm_timer.sv
module svpwm_timer #(
  parameter int unsigned PER = 400,
  parameter int unsigned TW  = 12,
  localparam int unsigned CW = $clog2(PER)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sector_in,
  input  logic [TW-1:0] ta_in,
  input  logic [TW-1:0] tb_in,
  output logic [CW-1:0] cnt,
  output logic          start,
  output logic [2:0]    sec_q,
  output logic [TW-1:0] ta_q,
  output logic [TW-1:0] tb_q
);
  localparam logic [TW:0]   PER_W = (TW+1)'(PER);
  localparam logic [CW-1:0] LAST  = CW'(PER - 1);

  logic [TW-1:0] ta_c, tb_c;
  logic [TW:0]   pair_sum;

  // Dwell-time limiting so the zero time never goes negative.
  always_comb begin
    if ({1'b0, ta_in} > PER_W) ta_c = PER_W[TW-1:0];
    else                       ta_c = ta_in;
    pair_sum = {1'b0, ta_c} + {1'b0, tb_in};
    if (pair_sum > PER_W) tb_c = PER_W[TW-1:0] - ta_c;
    else                  tb_c = tb_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= LAST;
      sec_q <= 3'd0;
      ta_q  <= '0;
      tb_q  <= '0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      sec_q <= sector_in;
      ta_q  <= ta_c;
      tb_q  <= tb_c;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign start = (cnt == '0);

endmodule

// File: rtl/svpwm_segmap.sv
module svpwm_segmap #(
  parameter int unsigned PER = 400,
  parameter int unsigned TW  = 12,
  localparam int unsigned CW = $clog2(PER)
) (
  input  logic [CW-1:0] cnt,
  input  logic [2:0]    sec_q,
  input  logic [TW-1:0] ta_q,
  input  logic [TW-1:0] tb_q,
  output logic [2:0]    seg,
  output logic          all_nz,
  output logic          d0_nz
);
  localparam logic [TW:0] PER_W = (TW+1)'(PER);
  localparam int unsigned NB = 7;

  logic [TW:0] t0, d0, da, db, dx, dy;
  logic [TW:0] cnt_x;

  assign t0    = PER_W - {1'b0, ta_q} - {1'b0, tb_q};
  assign d0    = t0 >> 2;
  assign da    = {1'b0, ta_q} >> 1;
  assign db    = {1'b0, tb_q} >> 1;
  // Odd sectors lead with Va, even sectors with Vb.
  assign dx    = sec_q[0] ? da : db;
  assign dy    = sec_q[0] ? db : da;
  assign cnt_x = (TW+1)'(cnt);

  assign d0_nz  = (d0 != '0);
  assign all_nz = d0_nz && (da != '0) && (db != '0);

  always_comb begin
    logic [TW:0] len [NB];
    logic [TW:0] acc;
    len[0] = d0; len[1] = dx; len[2] = dy; len[3] = d0;
    len[4] = d0; len[5] = dy; len[6] = dx;
    acc = '0;
    seg = 3'd0;
    for (int i = 0; i < NB; i++) begin
      acc = acc + len[i];
      if (cnt_x >= acc) seg = seg + 3'd1;
    end
  end

endmodule

// File: rtl/svpwm_statesel.sv
module svpwm_statesel
  import svpwm_pkg::*;
(
  input  logic [2:0] seg,
  input  logic [2:0] sec_q,
  output logic [2:0] state,
  output logic       valid
);
  logic [2:0] va, vb, first_v, second_v;

  assign valid    = sector_ok(sec_q);
  assign va       = active_vec(sec_q);
  assign vb       = active_vec(next_sector(sec_q));
  assign first_v  = sec_q[0] ? va : vb;
  assign second_v = sec_q[0] ? vb : va;

  always_comb begin
    if (!valid) state = 3'b000;
    else begin
      case (seg)
        3'd1, 3'd6: state = first_v;
        3'd2, 3'd5: state = second_v;
        3'd3, 3'd4: state = 3'b111;
        default:    state = 3'b000;
      endcase
    end
  end

endmodule

// File: rtl/svpwm_seq.sv
module svpwm_seq #(
  parameter int unsigned PER = 400,
  parameter int unsigned TW  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sector_in,
  input  logic [TW-1:0] ta_in,
  input  logic [TW-1:0] tb_in,
  output logic [2:0]    gate_hi,
  output logic [2:0]    gate_lo,
  output logic          period_start,
  output logic [2:0]    sector_o,
  output logic [2:0]    seg_o
);
  localparam int unsigned CW = $clog2(PER);

  logic [CW-1:0] cnt;
  logic [2:0]    sec_q;
  logic [TW-1:0] ta_q, tb_q;
  logic [2:0]    seg;
  logic [2:0]    state;
  // Named internal events for the checker.
  logic          all_nz;
  logic          d0_nz;
  logic          sec_valid;

  svpwm_timer #(.PER(PER), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .sector_in(sector_in), .ta_in(ta_in), .tb_in(tb_in),
    .cnt(cnt), .start(period_start), .sec_q(sec_q), .ta_q(ta_q), .tb_q(tb_q)
  );

  svpwm_segmap #(.PER(PER), .TW(TW)) u_segmap (
    .cnt(cnt), .sec_q(sec_q), .ta_q(ta_q), .tb_q(tb_q),
    .seg(seg), .all_nz(all_nz), .d0_nz(d0_nz)
  );

  svpwm_statesel u_sel (
    .seg(seg), .sec_q(sec_q), .state(state), .valid(sec_valid)
  );

  assign gate_hi  = state;
  assign gate_lo  = ~state;
  assign sector_o = sec_q;
  assign seg_o    = seg;

endmodule

// File: rtl/svpwm_seq_chk.sv
module svpwm_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       period_start,
  input logic [2:0] gate_hi,
  input logic [2:0] sector_o,
  input logic [2:0] seg_o,
  input logic       all_nz,
  input logic       d0_nz,
  input logic       sec_valid
);

  // R2
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);

  // R3
  p_sector_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !period_start |-> $stable(sector_o));

  // R6
  p_seg_forward_r6: assert property (@(posedge clk) disable iff (rst)
    !period_start |-> (seg_o >= $past(seg_o)));

  // R4
  p_open_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (period_start && sec_valid && d0_nz) |-> (gate_hi == 3'b000));

  // R9
  p_invalid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !sec_valid |-> (gate_hi == 3'b000));

  // R8
  p_one_leg_r8: assert property (@(posedge clk) disable iff (rst)
    (!period_start && all_nz) |-> ($countones(gate_hi ^ $past(gate_hi)) <= 1));

endmodule

bind svpwm_seq svpwm_seq_chk u_chk (
  .clk(clk), .rst(rst), .period_start(period_start), .gate_hi(gate_hi),
  .sector_o(sector_o), .seg_o(seg_o), .all_nz(all_nz), .d0_nz(d0_nz),
  .sec_valid(sec_valid)
);

// File: tb/svpwm_seq_test.sv
`timescale 1ns/1ps
module svpwm_seq_test;
  localparam int PER = 400;
  localparam int TW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    sector_in = 3'd0;
  logic [TW-1:0] ta_in = '0;
  logic [TW-1:0] tb_in = '0;
  logic [2:0]    gate_hi, gate_lo, sector_o, seg_o;
  logic          period_start;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  svpwm_seq #(.PER(PER), .TW(TW)) uut (
    .clk(clk), .rst(rst), .sector_in(sector_in), .ta_in(ta_in), .tb_in(tb_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .period_start(period_start),
    .sector_o(sector_o), .seg_o(seg_o)
  );

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got cycle %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Leg on-sets per active vector index.
  function automatic logic [2:0] bvec(input int k);
    logic [2:0] v;
    v[2] = (k == 1) || (k == 2) || (k == 6);
    v[1] = (k >= 2) && (k <= 4);
    v[0] = (k >= 4) && (k <= 6);
    return v;
  endfunction

  function automatic int lim_a(input int ta);
    return (ta > PER) ? PER : ta;
  endfunction

  function automatic int lim_b(input int ta, input int tb);
    int a;
    a = lim_a(ta);
    return (a + tb > PER) ? PER - a : tb;
  endfunction

  function automatic logic [2:0] exp_hi(input int c, input int s, input int ta, input int tb);
    int a, b, q, dp, dr, acc;
    logic [2:0] p, r;
    logic [2:0] sv [8];
    int dl [8];
    if (s < 1 || s > 6) return 3'b000;
    a = lim_a(ta); b = lim_b(ta, tb);
    q = (PER - a - b) / 4;
    if (s % 2 == 1) begin p = bvec(s); r = bvec(s % 6 + 1); dp = a / 2; dr = b / 2; end
    else begin p = bvec(s % 6 + 1); r = bvec(s); dp = b / 2; dr = a / 2; end
    sv = '{3'b000, p, r, 3'b111, 3'b111, r, p, 3'b000};
    dl = '{q, dp, dr, q, q, dr, dp, PER};
    acc = 0;
    for (int i = 0; i < 8; i++) begin
      acc += dl[i];
      if (c < acc) return sv[i];
    end
    return 3'b000;
  endfunction

  task automatic run_period(input int s, input int ta, input int tb, input string tag);
    int bad_c, bad_g, bad_e, lo_bad, ps_bad, multi, a, b;
    logic [2:0] got, exp, prev;
    logic nz;
    int sec_seen;
    sector_in = 3'(s); ta_in = TW'(ta); tb_in = TW'(tb);
    @(negedge clk);
    while (!period_start) @(negedge clk);
    a = lim_a(ta); b = lim_b(ta, tb);
    nz = ((PER - a - b) / 4 > 0) && (a / 2 > 0) && (b / 2 > 0) && s >= 1 && s <= 6;
    bad_c = -1; bad_g = 0; bad_e = 0; lo_bad = 0; ps_bad = 0; multi = 0;
    prev = 3'b000; sec_seen = 0;
    for (int c = 0; c < PER; c++) begin
      got = gate_hi;
      exp = exp_hi(c, s, ta, tb);
      if (got !== exp && bad_c < 0) begin bad_c = c; bad_g = got; bad_e = exp; end
      if (gate_lo !== ~gate_hi) lo_bad++;
      if (period_start !== (c == 0)) ps_bad++;
      if (c > 0 && nz && $countones(got ^ prev) > 1) multi++;
      prev = got;
      if (c == PER / 2) begin  // R3: disturb inputs mid-period
        sector_in = 3'($urandom_range(7)); ta_in = TW'($urandom_range(450));
        tb_in = TW'($urandom_range(450));
      end
      if (c == PER - 1) sec_seen = sector_o;
      @(negedge clk);
    end
    checks++;
    if (bad_c >= 0) begin
      errors++;
      $display("FAIL %s: cycle %0d of sector %0d ta %0d tb %0d got %b expected %b",
               tag, bad_c, s, ta, tb, bad_g[2:0], bad_e[2:0]);
    end
    check("R10 complement mismatches", lo_bad, 0);
    check("R2 start pulse misplacements", ps_bad, 0);
    check("R3 captured sector at end of period", sec_seen, s);
    if (nz) check("R8 multi-leg transitions", multi, 0);
  endtask

  initial begin
    process::self().srandom(32'd20240517);
    repeat (3) @(negedge clk);
    check("R1 gate_hi in reset", gate_hi, 0);
    check("R1 gate_lo in reset", gate_lo, 7);
    check("R1 period_start in reset", period_start, 0);
    @(negedge clk); rst = 1'b0;

    run_period(1, 100, 60,  "R4/R6 sector1");
    run_period(2, 100, 60,  "R5/R6 sector2");
    run_period(6, 80, 140,  "R5 sector6 wrap");
    run_period(3, 101, 63,  "R4/R6 odd remainders");
    run_period(4, 0, 0,     "R6 zero-only period");
    run_period(5, 1, 250,   "R6 skipped Va segment");
    run_period(1, 500, 30,  "R7 Ta over period");
    run_period(2, 300, 300, "R7 sum over period");
    run_period(0, 100, 60,  "R9 sector 0");
    run_period(7, 100, 60,  "R9 sector 7");
    for (int n = 0; n < 30; n++) begin
      int s, ta, tb;
      s  = $urandom_range(7);
      ta = $urandom_range(450);
      tb = $urandom_range(450);
      run_period(s, ta, tb, (s % 2 == 1) ? "R4/R6/R7 random" : "R5/R6/R7/R9 random");
    end
    summary();
  end

endmodule